// File: doc/BRIEF.md
# Interrupt Combiner and Discrete Output Port

This block is the shared, chip-level logic of a dual-channel serial controller. It gathers the transmit-ready and receive-ready flags of every channel into one interrupt status byte. It gates that byte with a write-only enable mask and drives one active-low interrupt request pin. The same byte bus also reaches a bank of discrete outputs. Their register bits are set and cleared only through two dedicated strobe offsets, so software never needs a read-modify-write. An output routing register chooses, for each pin, between the manual register bit and a live status flag. A read offset returns the levels on the input pins with their polarity inverted.

The request pin is produced by a two-state machine. The state `IRQ_QUIET` holds the pin high. The state `IRQ_RAISED` holds it low. The transition RAISE goes from `IRQ_QUIET` to `IRQ_RAISED` when any status bit that has its mask bit set is one. The transition DROP goes back when no such bit remains. Every other case holds the current state. The state is registered, so the pin follows the masked status one clock later. Status bits are live copies of the channel flags and need no clear operation.

Top module: `imo_unit`

## Requirements
- R1: Reset clears the mask, the output register and the routing register. As a result `irq_n` is 1 and every `out_pins` bit is 1.
- R2: A read at offset 0x5 returns the status byte in `rdata` in the cycle after `rd_en`. For channel n, transmit-ready sits at bit 4n and receive-ready at bit 4n+1. All other bits read 0.
- R3: A write at offset 0x5 loads the mask, which uses the same bit layout as the status byte. `irq_n` goes to 0 one clock after (status AND mask) becomes nonzero. It returns to 1 one clock after that product becomes zero.
- R4: Reading the status has no side effect. The status and `irq_n` stay the same while the channel flags are unchanged.
- R5: A write at offset 0xE sets each output register bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R6: A write at offset 0xF clears each output register bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R7: When routing bit k is 0, `out_pins[k]` drives the inverse of output register bit k, so a set bit drives the pin low.
- R8: A read at offset 0xD returns the bitwise inverse of `in_pins`, so a low pin reads as 1.
- R9: A write at offset 0xD loads the routing register. When routing bit k is 1, `out_pins[k]` drives the inverse of status bit k. Writing 0 returns every pin to manual control.
- R10: Writes to any other offset leave the mask, the output register and the routing register unchanged. Reads at any other offset return 0.
- R11: A routing write does not change the output register, and the mask can never be read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle |
| rd_en | input | 1 | Bus read strobe, one cycle |
| addr | input | ADDR_W | Register offset |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid the cycle after rd_en |
| tx_rdy | input | NCH | Per-channel transmit-ready flags |
| rx_rdy | input | NCH | Per-channel receive-ready flags |
| in_pins | input | DW | General input pins |
| out_pins | output | DW | General output pins |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The properties assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that `addr`, `wdata` and `in_pins` hold steady across the clock edge that samples them. The bench meets this by changing every input only on the falling clock edge. It also issues each bus access as a single one-cycle strobe with the other strobe held low. The ready flags change only between accesses, so each expected value follows from one known mask and one known flag pattern.

// File: rtl/imo_pkg.sv
package imo_pkg;
    localparam int OFS_INTR   = 5;
    localparam int OFS_INPORT = 13;
    localparam int OFS_OSET   = 14;
    localparam int OFS_OCLR   = 15;
    localparam int NIBBLE     = 4;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/imo_status_map.sv
module imo_status_map #(
    parameter int NCH = 2,
    parameter int DW  = 8
) (
    input  logic [NCH-1:0] tx_rdy,
    input  logic [NCH-1:0] rx_rdy,
    output logic [DW-1:0]  status
);
    import imo_pkg::*;

    localparam int USED = NCH * NIBBLE;

    initial begin
        if (USED > DW) $error("status byte too narrow for channel count");
    end

    // Each channel owns one nibble: bit 0 transmit, bit 1 receive.
    always_comb begin
        status = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            status[ch*NIBBLE]     = tx_rdy[ch];
            status[ch*NIBBLE + 1] = rx_rdy[ch];
        end
    end
endmodule

// File: rtl/imo_irq_ctrl.sv
module imo_irq_ctrl #(
    parameter int DW     = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     status,
    output logic              irq_n
);
    import imo_pkg::*;

    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_INTR);

    logic [DW-1:0] mask_q;
    logic          any_hit;
    irq_state_e    state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          mask_q <= '0;
        else if (wr_en && addr == A_MASK)    mask_q <= wdata;
    end

    assign any_hit = |(status & mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_hit)  state_d = IRQ_RAISED; // RAISE
            IRQ_RAISED: if (!any_hit) state_d = IRQ_QUIET;  // DROP
            default:                  state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/imo_out_port.sv
module imo_out_port #(
    parameter int DW     = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     status,
    output logic [DW-1:0]     port_q,
    output logic [DW-1:0]     out_pins
);
    import imo_pkg::*;

    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_OSET);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_OCLR);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_INPORT);

    logic [DW-1:0] route_q;

    // Set and clear strobes: a 1 in wdata acts, a 0 leaves the bit alone.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else if (wr_en) begin
            if (addr == A_SET)      port_q <= port_q | wdata;
            else if (addr == A_CLR) port_q <= port_q & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       route_q <= '0;
        else if (wr_en && addr == A_CFG)  route_q <= wdata;
    end

    for (genvar k = 0; k < DW; k++) begin : g_pin
        assign out_pins[k] = route_q[k] ? ~status[k] : ~port_q[k];
    end
endmodule

// File: rtl/imo_read_mux.sv
module imo_read_mux #(
    parameter int DW     = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     status,
    input  logic [DW-1:0]     in_pins,
    output logic [DW-1:0]     rdata
);
    import imo_pkg::*;

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_INTR);
    localparam logic [ADDR_W-1:0] A_INP  = ADDR_W'(OFS_INPORT);

    logic [DW-1:0] sel;

    always_comb begin
        sel = '0;
        if (addr == A_STAT)     sel = status;
        else if (addr == A_INP) sel = ~in_pins;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= sel;
    end
endmodule

// File: rtl/imo_unit.sv
module imo_unit #(
    parameter int NCH    = 2,
    parameter int DW     = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NCH-1:0]    tx_rdy,
    input  logic [NCH-1:0]    rx_rdy,
    input  logic [DW-1:0]     in_pins,
    output logic [DW-1:0]     out_pins,
    output logic              irq_n
);
    logic [DW-1:0] status;
    logic [DW-1:0] port_q;

    imo_status_map #(.NCH(NCH), .DW(DW)) u_map (
        .tx_rdy (tx_rdy),
        .rx_rdy (rx_rdy),
        .status (status)
    );

    imo_irq_ctrl #(.DW(DW), .ADDR_W(ADDR_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .status (status),
        .irq_n  (irq_n)
    );

    imo_out_port #(.DW(DW), .ADDR_W(ADDR_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .status   (status),
        .port_q   (port_q),
        .out_pins (out_pins)
    );

    imo_read_mux #(.DW(DW), .ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .addr    (addr),
        .status  (status),
        .in_pins (in_pins),
        .rdata   (rdata)
    );
endmodule

// File: rtl/imo_unit_chk.sv
module imo_unit_chk #(
    parameter int NCH    = 2,
    parameter int DW     = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic [DW-1:0]     rdata,
    input logic [NCH-1:0]    tx_rdy,
    input logic [NCH-1:0]    rx_rdy,
    input logic [DW-1:0]     in_pins,
    input logic              irq_n,
    input logic [DW-1:0]     port_q
);
    logic [DW-1:0] mask_sh;
    logic [DW-1:0] stat_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             mask_sh <= '0;
        else if (wr_en && addr == ADDR_W'(5))   mask_sh <= wdata;
    end

    always_comb begin
        stat_sh = '0;
        for (int c = 0; c < NCH; c++) begin
            stat_sh[4*c]   = tx_rdy[c];
            stat_sh[4*c+1] = rx_rdy[c];
        end
    end

    p_irq_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_sh & mask_sh)) |=> !irq_n);
    p_irq_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_sh & mask_sh)) |=> irq_n);
    p_status_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(5)) |=> rdata == $past(stat_sh));
    p_inport_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(13)) |=> rdata == ~$past(in_pins));
    p_set_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(14)) |=>
        port_q == ($past(port_q) | $past(wdata)));
    p_clr_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(15)) |=>
        port_q == ($past(port_q) & ~$past(wdata)));
    p_port_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == ADDR_W'(14) || addr == ADDR_W'(15))) |=> $stable(port_q));
endmodule

bind imo_unit imo_unit_chk #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .tx_rdy  (tx_rdy),
    .rx_rdy  (rx_rdy),
    .in_pins (in_pins),
    .irq_n   (irq_n),
    .port_q  (port_q)
);

// File: tb/imo_unit_bench.sv
module imo_unit_bench;
    localparam int NCH = 2;
    localparam int DW  = 8;
    localparam int AW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NCH-1:0] tx_rdy = '0;
    logic [NCH-1:0] rx_rdy = '0;
    logic [DW-1:0] in_pins = '1;
    logic [DW-1:0] out_pins;
    logic          irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;
    bit rd_seen  = 0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #4 clk = ~clk;

    imo_unit #(.NCH(NCH), .DW(DW), .ADDR_W(AW)) u_imo_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .in_pins(in_pins),
        .out_pins(out_pins), .irq_n(irq_n)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(int a, logic [DW-1:0] d);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(int a, logic [DW-1:0] exp, string tag);
        rd_en = 1'b1; addr = AW'(a);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: scoreboard pops one expectation per completed read.
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underrun", 8'h00, 8'h01);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        check("R1 out_pins", out_pins, 8'hFF);
        bus_read(5, 8'h00, "R1 status idle");

        // R2 status layout
        tx_rdy = 2'b01; rx_rdy = 2'b10;
        @(negedge clk);
        bus_read(5, 8'h21, "R2 tx0 rx1");
        tx_rdy = 2'b10; rx_rdy = 2'b01;
        @(negedge clk);
        bus_read(5, 8'h12, "R2 tx1 rx0");
        check("R1 mask zero keeps irq high", {7'd0, irq_n}, 8'h01);

        // R3 mask and timing
        bus_write(5, 8'h02);
        check("R3 one-cycle latency", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        check("R3 raised", {7'd0, irq_n}, 8'h00);

        // R4 reads have no side effect; R11 mask not readable
        bus_read(5, 8'h12, "R4 status reread");
        bus_read(5, 8'h12, "R11 mask not returned");
        check("R4 irq stays", {7'd0, irq_n}, 8'h00);

        // R3 drop then raise on channel 1 transmit
        rx_rdy = 2'b00;
        @(negedge clk);
        check("R3 dropped", {7'd0, irq_n}, 8'h01);
        bus_write(5, 8'h10);
        @(negedge clk);
        check("R3 raised ch1 tx", {7'd0, irq_n}, 8'h00);

        // R5/R6/R7 output register
        bus_write(14, 8'h05);
        check("R5 set 05", out_pins, 8'hFA);
        bus_write(14, 8'h30);
        check("R5 set 30", out_pins, 8'hCA);
        bus_write(15, 8'h14);
        check("R6 clear 14", out_pins, 8'hDE);
        bus_write(15, 8'h00);
        check("R6 clear none", out_pins, 8'hDE);

        // R8 input port
        in_pins = 8'h5A;
        @(negedge clk);
        bus_read(13, 8'hA5, "R8 inverted inputs");

        // R10 other offsets
        bus_write(12, 8'hFF);
        check("R10 pins unchanged", out_pins, 8'hDE);
        @(negedge clk);
        check("R10 irq unchanged", {7'd0, irq_n}, 8'h00);
        bus_read(12, 8'h00, "R10 read zero");

        // R11 routing write leaves register
        bus_write(13, 8'h00);
        check("R11 pins after cfg 0", out_pins, 8'hDE);

        // R9 routing a status bit
        rx_rdy = 2'b01;
        bus_write(13, 8'h02);
        check("R9 routed status", out_pins, 8'hDC);
        rx_rdy = 2'b00;
        #1;
        check("R9 routed follows", out_pins, 8'hDE);
        rx_rdy = 2'b01;
        @(negedge clk);
        bus_write(13, 8'h00);
        check("R7 manual again", out_pins, 8'hDE);

        repeat (3) @(negedge clk);
        check("scoreboard drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule